// File: doc/BRIEF.md
# Split-Word Binary-to-Residue Converter

This block turns an unsigned binary sample into its residue modulo a fixed modulus chosen at elaboration time. It feeds one channel of a filter that computes in residue arithmetic. The sample is split into a high half and a low half. The high half picks one of the equal-sized subranges of the input space. A small table gives the residue at which that subrange starts. The low half is the position inside the subrange, and a second table reduces it modulo the modulus. A small modular adder then combines the two partial residues.

Both tables are filled by elaboration-time functions. The structure is a fixed three-register pipeline. It accepts one sample per clock under a valid strobe and returns one residue per clock. The latency depends only on the number of pipeline registers and not on the sample width. There is no control state machine: the only sequencing is a valid bit that travels next to the data through the three registers. These are called the capture stage, the lookup stage and the sum stage.

Top module: `rc_residue_conv`

## Requirements
- R1: When `out_valid` is high, `out_res` equals the unsigned value of the `in_data` sample that was accepted with it, taken modulo `MOD`.
- R2: A sample presented with `in_valid` high at a rising edge appears on `out_res`, with `out_valid` high, after the third rising edge, counting that edge as the first. `out_valid` equals `in_valid` as it was three edges earlier.
- R3: Back-to-back samples, with `in_valid` high on consecutive edges, each produce their own residue on consecutive cycles, with no stall and no gap.
- R4: `out_res` is `$clog2(MOD)` bits wide and its value is always in the range 0 to `MOD-1`.
- R5: While `rst_n` is low, `out_valid` and `out_res` are both 0 after the next rising edge.
- R6: A sample presented with `in_valid` low has no effect. It produces a cycle with `out_valid` low three edges later, and during such cycles `out_res` keeps the last valid residue (0 if there has been none since reset).
- R7: The subrange boundaries convert correctly: 0, 2^(W/2)-1, 2^(W/2) and 2^W-1 for sample width W. This holds both when `MOD` is below 2^(W/2) and when it is above.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks `in_data` as a sample to convert |
| in_data | input | WIDTH | Unsigned binary sample |
| out_valid | output | 1 | Marks `out_res` as a fresh residue |
| out_res | output | $clog2(MOD) | Residue of the matching sample modulo MOD |

## Verification
Every residue is due exactly three rising edges after the edge that captures its sample. The `out_valid` gap left by a bubble is due at the same distance. The bench drives a sample at each falling edge and reads the outputs at the falling edge three periods later. It keeps a three-deep history of the samples it drove and compares each output with the entry that has just left that history. Two instances are checked in lockstep: a 16-bit converter modulo 9, and an 8-bit converter modulo 17, so that both the small-modulus case and the large-modulus case are covered.

// File: rtl/rc_pkg.sv
package rc_pkg;

    // residue that subrange j starts at: (j * 2^half) mod m
    function automatic int unsigned rc_sub_start(input int unsigned j,
                                                 input int unsigned half,
                                                 input int unsigned m);
        int unsigned step;
        step = (32'd1 << half) % m;
        return ((j % m) * step) % m;
    endfunction

    // residue of a low half-word value
    function automatic int unsigned rc_low_mod(input int unsigned r,
                                               input int unsigned m);
        return r % m;
    endfunction

endpackage

// File: rtl/rc_offset_rom.sv
module rc_offset_rom #(
    parameter int HALF = 8,
    parameter int MOD  = 9,
    parameter int RW   = $clog2(MOD)
) (
    input  logic [HALF-1:0] addr,
    output logic [RW-1:0]   val
);
    import rc_pkg::*;

    localparam int DEPTH = 1 << HALF;

    logic [RW-1:0] tab [DEPTH];

    for (genvar j = 0; j < DEPTH; j++) begin : g_ent
        assign tab[j] = RW'(rc_sub_start(j, HALF, MOD));
    end

    assign val = tab[addr];

    // R4
    always_comb begin
        off_range_chk: assert (!(^addr !== 1'bx) || (32'(val) < MOD));
    end
endmodule

// File: rtl/rc_low_rom.sv
module rc_low_rom #(
    parameter int HALF = 8,
    parameter int MOD  = 9,
    parameter int RW   = $clog2(MOD)
) (
    input  logic [HALF-1:0] addr,
    output logic [RW-1:0]   val
);
    import rc_pkg::*;

    localparam int DEPTH = 1 << HALF;

    logic [RW-1:0] tab [DEPTH];

    for (genvar r = 0; r < DEPTH; r++) begin : g_ent
        assign tab[r] = RW'(rc_low_mod(r, MOD));
    end

    assign val = tab[addr];

    // R4
    always_comb begin
        low_range_chk: assert (!(^addr !== 1'bx) || (32'(val) < MOD));
    end
endmodule

// File: rtl/rc_mod_add.sv
module rc_mod_add #(
    parameter int MOD = 9,
    parameter int RW  = $clog2(MOD)
) (
    input  logic [RW-1:0] a,
    input  logic [RW-1:0] b,
    output logic [RW-1:0] sum
);
    localparam logic [RW:0] MODV = (RW+1)'(MOD);

    logic [RW:0] raw;

    always_comb begin
        raw = {1'b0, a} + {1'b0, b};
        if (raw >= MODV) begin
            sum = RW'(raw - MODV);
        end else begin
            sum = raw[RW-1:0];
        end
    end

    // R1
    always_comb begin
        add_exact_chk: assert (!((^{a, b} !== 1'bx) && 32'(a) < MOD && 32'(b) < MOD)
                               || (32'(sum) == (32'(a) + 32'(b)) % MOD));
    end
endmodule

// File: rtl/rc_residue_conv.sv
module rc_residue_conv #(
    parameter int WIDTH = 16,
    parameter int MOD   = 9,
    parameter int RW    = $clog2(MOD)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_data,
    output logic             out_valid,
    output logic [RW-1:0]    out_res
);
    localparam int HALF = WIDTH / 2;

    // capture stage
    logic            cap_v;
    logic [HALF-1:0] cap_hi;
    logic [HALF-1:0] cap_lo;

    // lookup stage
    logic            lut_v;
    logic [RW-1:0]   lut_off;
    logic [RW-1:0]   lut_low;

    // combinational paths between stages
    logic [RW-1:0]   off_w;
    logic [RW-1:0]   low_w;
    logic [RW-1:0]   sum_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_v  <= 1'b0;
            cap_hi <= '0;
            cap_lo <= '0;
        end else begin
            cap_v <= in_valid;
            if (in_valid) begin
                cap_hi <= in_data[WIDTH-1 -: HALF];
                cap_lo <= in_data[HALF-1:0];
            end
        end
    end

    rc_offset_rom #(.HALF(HALF), .MOD(MOD), .RW(RW)) u_off (
        .addr (cap_hi),
        .val  (off_w)
    );

    rc_low_rom #(.HALF(HALF), .MOD(MOD), .RW(RW)) u_low (
        .addr (cap_lo),
        .val  (low_w)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lut_v   <= 1'b0;
            lut_off <= '0;
            lut_low <= '0;
        end else begin
            lut_v <= cap_v;
            if (cap_v) begin
                lut_off <= off_w;
                lut_low <= low_w;
            end
        end
    end

    rc_mod_add #(.MOD(MOD), .RW(RW)) u_add (
        .a   (lut_off),
        .b   (lut_low),
        .sum (sum_w)
    );

    // sum stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_res   <= '0;
        end else begin
            out_valid <= lut_v;
            if (lut_v) begin
                out_res <= sum_w;
            end
        end
    end

    // R2
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid, 3));

    // R1
    residue_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (64'(out_res) == 64'($past(in_data, 3)) % 64'(MOD)));

    // R6
    bubble_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_res));

    // R4
    out_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(out_res) < MOD);
endmodule

// File: tb/rc_residue_conv_test.sv
module rc_residue_conv_test;

    localparam int WA = 16;
    localparam int MA = 9;
    localparam int RA = $clog2(MA);
    localparam int WB = 8;
    localparam int MB = 17;
    localparam int RB = $clog2(MB);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [WA-1:0] in_data = '0;
    logic          ov_a;
    logic [RA-1:0] or_a;
    logic          ov_b;
    logic [RB-1:0] or_b;

    int checks = 0;
    int fails = 0;

    // model history: index 0 newest
    logic        hv [3];
    logic [31:0] hd [3];
    int unsigned last_a;
    int unsigned last_b;

    always #10 clk = ~clk;

    rc_residue_conv #(.WIDTH(WA), .MOD(MA)) uut (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_data (in_data),
        .out_valid (ov_a), .out_res (or_a)
    );

    rc_residue_conv #(.WIDTH(WB), .MOD(MB)) uut_b (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_data (in_data[WB-1:0]),
        .out_valid (ov_b), .out_res (or_b)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clear_model();
        for (int i = 0; i < 3; i++) begin
            hv[i] = 1'b0;
            hd[i] = '0;
        end
        last_a = 0;
        last_b = 0;
    endtask

    // one clock: check outputs due now, then drive the next input
    task automatic step(input logic [WA-1:0] d, input logic v, input string tag);
        int unsigned ea;
        int unsigned eb;
        @(negedge clk);
        if (hv[2]) begin
            ea = hd[2] % MA;
            eb = (hd[2] & 32'hFF) % MB;
            last_a = ea;
            last_b = eb;
        end else begin
            ea = last_a;
            eb = last_b;
        end
        chk(ov_a == hv[2], {tag, " valid mod9"}, ov_a, hv[2]);
        chk(32'(or_a) == ea, {tag, " res mod9"}, or_a, ea);
        chk(ov_b == hv[2], {tag, " valid mod17"}, ov_b, hv[2]);
        chk(32'(or_b) == eb, {tag, " res mod17"}, or_b, eb);
        chk(32'(or_a) < MA && 32'(or_b) < MB, "R4 range", or_b, MB - 1);
        hv[2] = hv[1]; hd[2] = hd[1];
        hv[1] = hv[0]; hd[1] = hd[0];
        hv[0] = v;     hd[0] = 32'(d);
        in_valid = v;
        in_data = d;
    endtask

    task automatic flush(input string tag);
        for (int i = 0; i < 3; i++) step('0, 1'b0, tag);
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        in_valid = 1'b0;
        in_data = 16'hBEEF;
        repeat (3) @(negedge clk);
        chk(ov_a == 1'b0 && ov_b == 1'b0, "R5 reset valid", {ov_a, ov_b}, 0);
        chk(or_a == '0 && or_b == '0, "R5 reset res", {or_a, or_b}, 0);
        clear_model();
        rst_n = 1'b1;
    endtask

    task automatic test_latency();
        step(16'd12345, 1'b1, "R2");
        step(16'hFFFF, 1'b0, "R2");
        step(16'hFFFF, 1'b0, "R2");
        flush("R2");
    endtask

    task automatic test_endpoints();
        // sample-width boundaries for the 16-bit instance
        step(16'h0000, 1'b1, "R7");
        step(16'h00FF, 1'b1, "R7");
        step(16'h0100, 1'b1, "R7");
        step(16'hFFFF, 1'b1, "R7");
        // boundaries for the 8-bit instance (low byte): 0x0F, 0x10, 0xFF
        step(16'h000F, 1'b1, "R7");
        step(16'h0010, 1'b1, "R7");
        step(16'h01FF, 1'b1, "R7");
        step(16'hFF00, 1'b1, "R7");
        flush("R7");
    endtask

    task automatic test_stream();
        for (int i = 0; i < 400; i++) step(16'($urandom), 1'b1, "R3");
        flush("R3");
    endtask

    task automatic test_bubbles();
        for (int i = 0; i < 400; i++) begin
            logic v;
            v = ($urandom % 3) != 0;
            step(16'($urandom), v, v ? "R1" : "R6");
        end
        flush("R6");
    endtask

    initial begin
        clear_model();
        test_reset();
        test_latency();
        test_endpoints();
        test_stream();
        test_bubbles();
        step(16'd999, 1'b1, "R1");
        step(16'd1000, 1'b1, "R1");
        test_reset();
        flush("R5");
        test_endpoints();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule